// File: doc/BRIEF.md
# Match-Triggered Watchdog Timer

This block is a watchdog peripheral built around a free-running up-counter. The counter advances once for each pulse of a fixed-rate tick enable. Each time it advances, it is compared with a programmed compare value. On equality the block can take any combination of these actions: latch an interrupt flag, halt and zero the counter, change the level of an external compare pin, and launch an on-chip or an off-chip reset pulse. Software can also launch either reset pulse directly. The pulse length is set by a register and is counted in ticks.

Software reaches the block through a plain word-indexed register bus. There are eight registers, selected by a 3-bit index. Writes take effect on the clock edge. Reads are combinational. A debug-halt input can freeze the counter while a debugger holds the core, but only if software has opted in. A sticky cause flag records that a reset pulse came from this block. The flag survives the block's own on-chip reset and is cleared only by the power-on reset.

Register indices: 0 interrupt flag, 1 control, 2 counter (read only), 3 compare-action control, 4 compare value, 5 pin control, 6 pulse length, 7 reset cause.

Top module: `wdm_timer`

## Requirements
- R1: After `por_n` is released, all eight registers read zero and `irq`, `match_pin`, `int_rst` and `ext_rst` are low.
- R2: The counter increments by one on each clock edge where `tick` is high and control bit 0 is set. It holds its value when `tick` is low. Writing 0 to the control register stops the counter but leaves its value in place. Writes to index 2 are ignored.
- R3: Writing control bit 1 as 1 clears the counter to zero at that write's edge, so the next read returns 0. The counter stays at zero for as long as bit 1 remains set, even if bit 0 is also set.
- R4: While control bit 2 is set and `dbg_halt` is high, the counter holds. When control bit 2 is clear, `dbg_halt` has no effect.
- R5: A compare event occurs on a counting edge where the counter equals the compare value. The event sets interrupt flag bit 0. `irq` is the AND of that flag and compare-action bit 0. Writing 1 to flag bit 0 clears it; writing 0 leaves it set.
- R6: If compare-action bit 2 is set, a compare event zeroes the counter and clears control bit 0. If bit 2 is clear, the counter moves on to compare value + 1.
- R7: On a compare event, the pin-control field at bits [5:4] sets the new pin level. The codes are: 0 keep, 1 drive low, 2 drive high, 3 invert. Bit 0 of the pin-control register holds the pin level, can be written, and drives `match_pin`.
- R8: A compare event launches a pulse on `int_rst` if compare-action bit 3 is set, and on `ext_rst` if bit 4 is set. Each pulse is high for (pulse length + 6) ticks, starting on the edge of the event.
- R9: Writing compare-action bit 5 or bit 6 as 1 launches one pulse on `int_rst` or `ext_rst` respectively, starting at the write's edge. The bit reads 1 for the length of the pulse and clears itself when the pulse ends.
- R10: Reset-cause bit 0 is set when either pulse is launched. Only `por_n` clears it; bus writes and the internal reset do not.
- R11: When an `int_rst` pulse ends, every register except the reset-cause flag returns to its R1 value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| tick | input | 1 | Fixed-rate count enable |
| dbg_halt | input | 1 | Debugger holds the core |
| bus_addr | input | 3 | Register index |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| irq | output | 1 | Compare interrupt |
| match_pin | output | 1 | External compare pin |
| int_rst | output | 1 | On-chip reset pulse |
| ext_rst | output | 1 | Off-chip reset pulse |

## Verification
The bench sweeps every pin-action code against both starting pin levels. A design that decoded the field off by one bit would drive high where it should invert. The bench also sweeps several pulse lengths and measures each pulse width cycle by cycle, which catches a pulse that runs short or long by a tick. It looks for the compare event exactly one edge after the counter reads the compare value. An early or late event shows up as the flag or the stop appearing a cycle off. Finally, it checks that the cause flag survives both the internal reset and a bus write, and that every other register is cleared when the internal pulse ends.

// File: rtl/wdm_pkg.sv
package wdm_pkg;
    parameter int DATA_W  = 32;
    parameter int CNT_W   = 32;
    parameter int PULSE_W = 16;
    parameter int ADDR_W  = 3;
    parameter int MC_W    = 7;

    localparam int NPULSE  = 2;
    localparam int ACT_LSB = 4;

    // compare-action control bit positions
    localparam int MC_IE   = 0;
    localparam int MC_STOP = 2;
    localparam int MC_INTR = 3;   // MC_INTR + 1 selects the off-chip pulse
    localparam int MC_FINT = 5;   // MC_FINT + 1 forces the off-chip pulse

    typedef enum logic [ADDR_W-1:0] {
        RG_IST   = 3'd0,
        RG_CTRL  = 3'd1,
        RG_CNT   = 3'd2,
        RG_MCTRL = 3'd3,
        RG_MATCH = 3'd4,
        RG_EMR   = 3'd5,
        RG_PULSE = 3'd6,
        RG_RSTAT = 3'd7
    } reg_idx_e;

    typedef enum logic [1:0] {
        PA_KEEP   = 2'd0,
        PA_LOW    = 2'd1,
        PA_HIGH   = 2'd2,
        PA_INVERT = 2'd3
    } pin_act_e;

    typedef struct packed {
        logic               ist;
        logic               en;
        logic               crst;
        logic               frz;
        logic [MC_W-1:0]    mc;
        logic [CNT_W-1:0]   match;
        pin_act_e           act;
        logic               pin;
        logic [PULSE_W-1:0] plen;
    } regs_t;

    localparam regs_t REGS_RST = '0;
endpackage

// File: rtl/wdm_count.sv
module wdm_count #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         por_n,
    input  logic         clr,
    input  logic         run,
    input  logic         tick,
    input  logic [W-1:0] match_val,
    input  logic         stop_on_hit,
    output logic [W-1:0] cnt,
    output logic         hit
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        hit   = run & tick & ~clr & (cnt_q == match_val);
        cnt_d = cnt_q;
        if (clr) begin
            cnt_d = '0;
        end else if (run && tick) begin
            if (hit && stop_on_hit) begin
                cnt_d = '0;
            end else begin
                cnt_d = cnt_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign cnt = cnt_q;
endmodule

// File: rtl/wdm_pulse.sv
module wdm_pulse #(
    parameter int LEN_W = 16,
    parameter int EXTRA = 6
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             tick,
    input  logic             start,
    input  logic [LEN_W-1:0] len,
    output logic             active,
    output logic             done
);
    localparam int REM_W = LEN_W + 1;

    typedef struct packed {
        logic             act;
        logic [REM_W-1:0] rem;
    } pst_t;

    pst_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        done = st_q.act & tick & (st_q.rem == '0);
        if (st_q.act) begin
            if (tick) begin
                if (st_q.rem == '0) begin
                    st_d.act = 1'b0;
                end else begin
                    st_d.rem = st_q.rem - 1'b1;
                end
            end
        end else if (start) begin
            st_d.act = 1'b1;
            st_d.rem = {1'b0, len} + REM_W'(EXTRA - 1);
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign active = st_q.act;
endmodule

// File: rtl/wdm_timer.sv
module wdm_timer
    import wdm_pkg::*;
#(
    parameter int PULSE_EXTRA = 6
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              tick,
    input  logic              dbg_halt,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq,
    output logic              match_pin,
    output logic              int_rst,
    output logic              ext_rst
);
    regs_t r_d, r_q;
    logic  cause_d, cause_q;

    logic [CNT_W-1:0]  cnt;
    logic              hit;
    logic              run;
    logic              cnt_clr;
    logic              wr_ctrl;
    logic              wr_mc;
    logic [NPULSE-1:0] pstart;
    logic [NPULSE-1:0] pact;
    logic [NPULSE-1:0] pdone;

    // taps for the bound checker
    logic en_q_w, crst_q_w, ie_q_w;
    assign en_q_w   = r_q.en;
    assign crst_q_w = r_q.crst;
    assign ie_q_w   = r_q.mc[MC_IE];

    assign wr_ctrl = bus_we && (bus_addr == RG_CTRL);
    assign wr_mc   = bus_we && (bus_addr == RG_MCTRL);
    assign run     = r_q.en & ~(r_q.frz & dbg_halt);
    assign cnt_clr = pdone[0] | r_q.crst | (wr_ctrl & bus_wdata[1]);

    wdm_count #(.W(CNT_W)) u_cnt (
        .clk        (clk),
        .por_n      (por_n),
        .clr        (cnt_clr),
        .run        (run),
        .tick       (tick),
        .match_val  (r_q.match),
        .stop_on_hit(r_q.mc[MC_STOP]),
        .cnt        (cnt),
        .hit        (hit)
    );

    for (genvar g = 0; g < NPULSE; g++) begin : g_pulse
        assign pstart[g] = (wr_mc & bus_wdata[MC_FINT + g] & ~r_q.mc[MC_FINT + g])
                         | (hit & r_q.mc[MC_INTR + g]);
        wdm_pulse #(.LEN_W(PULSE_W), .EXTRA(PULSE_EXTRA)) u_pg (
            .clk   (clk),
            .por_n (por_n),
            .tick  (tick),
            .start (pstart[g]),
            .len   (r_q.plen),
            .active(pact[g]),
            .done  (pdone[g])
        );
    end

    always_comb begin
        r_d     = r_q;
        cause_d = cause_q;
        if (bus_we) begin
            case (bus_addr)
                RG_IST: begin
                    if (bus_wdata[0]) r_d.ist = 1'b0;
                end
                RG_CTRL: begin
                    r_d.en   = bus_wdata[0];
                    r_d.crst = bus_wdata[1];
                    r_d.frz  = bus_wdata[2];
                end
                RG_MCTRL: begin
                    r_d.mc = bus_wdata[MC_W-1:0];
                    for (int k = 0; k < NPULSE; k++) begin
                        r_d.mc[MC_FINT + k] = r_q.mc[MC_FINT + k] | bus_wdata[MC_FINT + k];
                    end
                end
                RG_MATCH: r_d.match = bus_wdata[CNT_W-1:0];
                RG_EMR: begin
                    r_d.act = pin_act_e'(bus_wdata[ACT_LSB +: 2]);
                    r_d.pin = bus_wdata[0];
                end
                RG_PULSE: r_d.plen = bus_wdata[PULSE_W-1:0];
                default: ;
            endcase
        end
        if (hit) begin
            r_d.ist = 1'b1;
            if (r_q.mc[MC_STOP]) r_d.en = 1'b0;
            case (r_q.act)
                PA_LOW:    r_d.pin = 1'b0;
                PA_HIGH:   r_d.pin = 1'b1;
                PA_INVERT: r_d.pin = ~r_q.pin;
                default:   ;
            endcase
        end
        for (int k = 0; k < NPULSE; k++) begin
            if (pdone[k]) r_d.mc[MC_FINT + k] = 1'b0;
        end
        if (|pstart) cause_d = 1'b1;
        if (pdone[0]) r_d = REGS_RST;
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            r_q     <= REGS_RST;
            cause_q <= 1'b0;
        end else begin
            r_q     <= r_d;
            cause_q <= cause_d;
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            RG_IST:   bus_rdata[0] = r_q.ist;
            RG_CTRL:  bus_rdata[2:0] = {r_q.frz, r_q.crst, r_q.en};
            RG_CNT:   bus_rdata = DATA_W'(cnt);
            RG_MCTRL: bus_rdata[MC_W-1:0] = r_q.mc;
            RG_MATCH: bus_rdata = DATA_W'(r_q.match);
            RG_EMR: begin
                bus_rdata[ACT_LSB +: 2] = r_q.act;
                bus_rdata[0]            = r_q.pin;
            end
            RG_PULSE: bus_rdata = DATA_W'(r_q.plen);
            RG_RSTAT: bus_rdata[0] = cause_q;
            default:  bus_rdata = '0;
        endcase
    end

    assign irq       = r_q.ist & r_q.mc[MC_IE];
    assign match_pin = r_q.pin;
    assign int_rst   = pact[0];
    assign ext_rst   = pact[1];
endmodule

// File: rtl/wdm_timer_chk.sv
module wdm_timer_chk
    import wdm_pkg::*;
(
    input logic             clk,
    input logic             por_n,
    input logic             en_q,
    input logic             crst_q,
    input logic             ie_q,
    input logic             clr,
    input logic [CNT_W-1:0] cnt,
    input logic             irq,
    input logic             cause,
    input logic             int_rst,
    input logic             ext_rst
);
    // R2
    stopped_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
        (!en_q && !clr) |=> $stable(cnt));

    // R3
    clear_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
        crst_q |=> (cnt == '0));

    // R5
    irq_gate_chk: assert property (@(posedge clk) disable iff (!por_n)
        irq |-> ie_q);

    // R8
    int_width_chk: assert property (@(posedge clk) disable iff (!por_n)
        $rose(int_rst) |=> int_rst);

    // R8
    ext_width_chk: assert property (@(posedge clk) disable iff (!por_n)
        $rose(ext_rst) |=> ext_rst);

    // R10
    cause_sticky_chk: assert property (@(posedge clk) disable iff (!por_n)
        !$fell(cause));

    // R10
    cause_on_pulse_chk: assert property (@(posedge clk) disable iff (!por_n)
        ($rose(int_rst) || $rose(ext_rst)) |-> cause);
endmodule

bind wdm_timer wdm_timer_chk u_chk (
    .clk    (clk),
    .por_n  (por_n),
    .en_q   (en_q_w),
    .crst_q (crst_q_w),
    .ie_q   (ie_q_w),
    .clr    (cnt_clr),
    .cnt    (cnt),
    .irq    (irq),
    .cause  (cause_q),
    .int_rst(int_rst),
    .ext_rst(ext_rst)
);

// File: tb/sim_wdm_timer.sv
module sim_wdm_timer;
    import wdm_pkg::*;

    logic        clk = 1'b0;
    logic        por_n = 1'b0;
    logic        tick = 1'b1;
    logic        dbg_halt = 1'b0;
    logic [2:0]  bus_addr = 3'd0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = 32'd0;
    logic [31:0] bus_rdata;
    logic        irq, match_pin, int_rst, ext_rst;

    int total = 0;
    int bad = 0;

    always #5 clk = ~clk;

    wdm_timer u0 (
        .clk(clk), .por_n(por_n), .tick(tick), .dbg_halt(dbg_halt),
        .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq(irq), .match_pin(match_pin),
        .int_rst(int_rst), .ext_rst(ext_rst)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_we    = 1'b1;
        @(negedge clk);
        bus_we    = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    task automatic watch(input bit use_ext, output int first_i, output int hi);
        first_i = -1;
        hi = 0;
        for (int i = 0; i < 20; i++) begin
            if (use_ext ? ext_rst : int_rst) begin
                if (first_i < 0) first_i = i;
                hi++;
            end
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total + 1, bad + 1);
        $finish;
    end

    initial begin
        logic [31:0] v, a;
        int fi, hi;

        repeat (3) @(negedge clk);
        por_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        for (int r = 0; r < 8; r++) begin
            rd(3'(r), v);
            chk("R1 reg", v, 32'd0);
        end
        chk("R1 outs", {28'd0, irq, match_pin, int_rst, ext_rst}, 32'd0);

        // R2 counting, tick gating, stop without clear, read-only counter
        wr(RG_CTRL, 32'h1);
        rd(RG_CNT, v); chk("R2 start", v, 32'd0);
        repeat (6) @(negedge clk);
        rd(RG_CNT, v); chk("R2 count", v, 32'd6);
        tick = 1'b0;
        rd(RG_CNT, a);
        repeat (4) @(negedge clk);
        rd(RG_CNT, v); chk("R2 no tick", v, a);
        tick = 1'b1;
        wr(RG_CTRL, 32'h0);
        rd(RG_CNT, a);
        chk("R2 kept", {31'd0, a != 0}, 32'd1);
        repeat (5) @(negedge clk);
        rd(RG_CNT, v); chk("R2 stopped", v, a);
        wr(RG_CNT, 32'h55);
        rd(RG_CNT, v); chk("R2 cnt write ignored", v, a);

        // R3 counter clear request
        wr(RG_CTRL, 32'h2);
        rd(RG_CNT, v); chk("R3 cleared", v, 32'd0);
        wr(RG_CTRL, 32'h3);
        repeat (3) @(negedge clk);
        rd(RG_CNT, v); chk("R3 held", v, 32'd0);
        wr(RG_CTRL, 32'h1);
        rd(RG_CNT, v); chk("R3 release", v, 32'd0);
        repeat (2) @(negedge clk);
        rd(RG_CNT, v); chk("R3 resumes", v, 32'd2);

        // R4 debug freeze
        dbg_halt = 1'b1;
        wr(RG_CTRL, 32'h5);
        rd(RG_CNT, a);
        repeat (4) @(negedge clk);
        rd(RG_CNT, v); chk("R4 frozen", v, a);
        dbg_halt = 1'b0;
        rd(RG_CNT, a);
        repeat (3) @(negedge clk);
        rd(RG_CNT, v); chk("R4 unfrozen", v, a + 32'd3);
        wr(RG_CTRL, 32'h1);
        dbg_halt = 1'b1;
        rd(RG_CNT, a);
        repeat (3) @(negedge clk);
        rd(RG_CNT, v); chk("R4 halt ignored", v, a + 32'd3);
        dbg_halt = 1'b0;

        // R5 compare flag and interrupt; R6 continue past compare
        wr(RG_CTRL, 32'h2);
        wr(RG_MATCH, 32'd10);
        wr(RG_MCTRL, 32'h1);
        wr(RG_IST, 32'h1);
        wr(RG_CTRL, 32'h1);
        for (int i = 0; i <= 12; i++) begin
            rd(RG_CNT, v); chk("R6 runs on", v, 32'(i));
            rd(RG_IST, v); chk("R5 flag", v, {31'd0, i >= 11});
            chk("R5 irq", {31'd0, irq}, {31'd0, i >= 11});
            @(negedge clk);
        end
        wr(RG_MCTRL, 32'h0);
        chk("R5 irq masked", {31'd0, irq}, 32'd0);
        wr(RG_IST, 32'h0);
        rd(RG_IST, v); chk("R5 write0 keeps", v, 32'd1);
        wr(RG_IST, 32'h1);
        rd(RG_IST, v); chk("R5 write1 clears", v, 32'd0);
        wr(RG_CTRL, 32'h0);

        // R6 stop on compare
        wr(RG_CTRL, 32'h2);
        wr(RG_MATCH, 32'd5);
        wr(RG_MCTRL, 32'h4);
        wr(RG_CTRL, 32'h1);
        for (int i = 0; i <= 8; i++) begin
            rd(RG_CNT, v); chk("R6 stop cnt", v, (i <= 5) ? 32'(i) : 32'd0);
            rd(RG_CTRL, v); chk("R6 stop en", v, {31'd0, i <= 5});
            @(negedge clk);
        end

        // R7 pin action sweep: every code against both start levels
        for (int act = 0; act < 4; act++) begin
            for (int p = 0; p < 2; p++) begin
                logic e;
                e = (act == 0) ? 1'(p) : (act == 1) ? 1'b0 : (act == 2) ? 1'b1 : ~1'(p);
                wr(RG_CTRL, 32'h2);
                wr(RG_EMR, 32'((act << 4) | p));
                wr(RG_MATCH, 32'd3);
                wr(RG_CTRL, 32'h1);
                repeat (3) @(negedge clk);
                chk("R7 pin before", {31'd0, match_pin}, 32'(p));
                @(negedge clk);
                chk("R7 pin after", {31'd0, match_pin}, {31'd0, e});
                rd(RG_EMR, v); chk("R7 readback", v, 32'((act << 4) | int'(e)));
            end
        end

        // R8 compare-launched off-chip pulse, length sweep
        wr(RG_EMR, 32'h0);
        for (int p = 0; p < 4; p++) begin
            wr(RG_PULSE, 32'(p));
            wr(RG_MCTRL, 32'h14);
            wr(RG_CTRL, 32'h2);
            wr(RG_MATCH, 32'd3);
            wr(RG_CTRL, 32'h1);
            watch(1'b1, fi, hi);
            chk("R8 start edge", 32'(fi), 32'd4);
            chk("R8 width", 32'(hi), 32'(p + 6));
            chk("R8 no int", {31'd0, int_rst}, 32'd0);
        end
        rd(RG_RSTAT, v); chk("R10 cause set", v, 32'd1);

        // R9 forced off-chip pulse with self-clearing bit
        wr(RG_MCTRL, 32'h0);
        wr(RG_PULSE, 32'd3);
        wr(RG_MCTRL, 32'h40);
        rd(RG_MCTRL, v); chk("R9 force bit set", v, 32'h40);
        watch(1'b1, fi, hi);
        chk("R9 start", 32'(fi), 32'd0);
        chk("R9 width", 32'(hi), 32'd9);
        rd(RG_MCTRL, v); chk("R9 self clear", v, 32'h0);

        // R11 internal pulse clears everything but the cause flag
        wr(RG_MATCH, 32'd7);
        wr(RG_PULSE, 32'd1);
        wr(RG_EMR, 32'h21);
        wr(RG_CTRL, 32'h1);
        wr(RG_MCTRL, 32'h21);
        watch(1'b0, fi, hi);
        chk("R9 int start", 32'(fi), 32'd0);
        chk("R8 int width", 32'(hi), 32'd7);
        for (int r = 0; r < 7; r++) begin
            rd(3'(r), v);
            chk("R11 cleared", v, 32'd0);
        end
        chk("R11 outs", {29'd0, irq, match_pin, int_rst}, 32'd0);
        rd(RG_RSTAT, v); chk("R10 survives int reset", v, 32'd1);
        wr(RG_RSTAT, 32'h0);
        rd(RG_RSTAT, v); chk("R10 write ignored", v, 32'd1);

        // R10 power-on reset clears the flag
        @(negedge clk);
        por_n = 1'b0;
        repeat (2) @(negedge clk);
        por_n = 1'b1;
        @(negedge clk);
        rd(RG_RSTAT, v); chk("R10 por clears", v, 32'd0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule